// File: doc/BRIEF.md
# Shift-and-Add Address Unit

This block forms `(B << (SH+1)) + A` over 64 bits, the usual scaled-index step of address arithmetic. The shift distance is a 2-bit immediate biased by one, so the addend `B` moves left by 1, 2, 3 or 4 places. Bits shifted past the top are lost. Zeros enter from the bottom. Any carry out of the most significant bit is discarded.

A mode input chooses how `B` is formed before the shift:
- The full 64-bit operand.
- The low 32-bit word, sign-extended.
- The low 32-bit word, zero-extended.

When the record input is set, a 4-bit condition field is also written. It holds the signed comparison of the result with zero, plus a summary-overflow bit copied from an input. When the record input is clear, the field keeps its previous value.

The arithmetic is purely combinational. The sum and the condition field are captured in output registers, so results appear one clock after the operands are presented. Reset clears both registers.

Top module: `shadd_unit`

## Requirements
- R1: The shift distance is `sh_i + 1`. Codes 0, 1, 2 and 3 shift by 1, 2, 3 and 4 places, so the low `sh_i+1` bits of the shifted operand are always zero.
- R2: `sum_o` equals the shifted operand plus `ra_i`, modulo 2^64. Bits shifted out above bit 63 and the final carry are dropped.
- R3: With `mode_i` = 2'b00 or 2'b11, the shifted operand is the full 64-bit `rb_i`.
- R4: With `mode_i` = 2'b01, the operand is `rb_i[31:0]` with bits 63:32 copied from `rb_i[31]`.
- R5: With `mode_i` = 2'b10, the operand is `rb_i[31:0]` with bits 63:32 forced to zero.
- R6: `cr0_o` is written only in a cycle where `rc_i` is 1. When `rc_i` is 0, `cr0_o` holds its value while `sum_o` still updates.
- R7: When written, `cr0_o[3]` (LT) is set if the result is negative as a signed 64-bit value, `cr0_o[2]` (GT) if it is positive and nonzero, and `cr0_o[1]` (EQ) if it is zero. Exactly one of the three is set.
- R8: When written, `cr0_o[0]` (SO) takes the value of `so_i`.
- R9: Outputs register the inputs present at a rising clock edge and are visible after that edge. An active-low `rst_n` clears `sum_o` and `cr0_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_i | input | 64 | Addend A |
| rb_i | input | 64 | Operand B, shifted before the add |
| sh_i | input | 2 | Shift immediate; the distance is sh_i+1 |
| mode_i | input | 2 | 00/11 full, 01 signed word, 10 unsigned word |
| rc_i | input | 1 | Record enable for the condition field |
| so_i | input | 1 | Summary-overflow bit to record |
| sum_o | output | 64 | Registered result |
| cr0_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The sum register and the condition-field register are written on the same clock edge. The risk is that the condition update is tied to the wrong event. The bench issues back-to-back operations in which `rc_i` alternates. When `rc_i` is clear, it checks that the sum takes the new value while the condition field still shows the flags of the last recorded result. When `rc_i` is set, it checks that the flags describe the sum written on that same edge, not the previous one.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_SWORD = 2'b01,
        MODE_UWORD = 2'b10,
        MODE_ALT   = 2'b11
    } shadd_mode_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_field_t;
endpackage

// File: rtl/shadd_extend.sv
module shadd_extend #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]          rb_i,
    input  shadd_pkg::shadd_mode_e   mode_i,
    output logic [XLEN-1:0]          ext_o
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] upper_fill;

    always_comb begin
        unique case (mode_i)
            shadd_pkg::MODE_SWORD: upper_fill = {HALF{rb_i[HALF-1]}};
            shadd_pkg::MODE_UWORD: upper_fill = '0;
            default:               upper_fill = rb_i[XLEN-1:HALF];
        endcase
        ext_o = {upper_fill, rb_i[HALF-1:0]};
    end
endmodule

// File: rtl/shadd_shift.sv
module shadd_shift #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SH_W-1:0] sh_i,
    output logic [XLEN-1:0] shifted_o
);
    localparam int NAMT = 1 << SH_W;

    logic [XLEN-1:0] cand [NAMT];

    for (genvar k = 0; k < NAMT; k++) begin : g_amt
        assign cand[k] = {val_i[XLEN-2-k:0], {(k+1){1'b0}}};
    end

    assign shifted_o = cand[sh_i];
endmodule

// File: rtl/shadd_flags.sv
module shadd_flags #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]        res_i,
    input  logic                   so_i,
    output shadd_pkg::cond_field_t flags_o
);
    logic is_zero;

    always_comb begin
        is_zero     = (res_i == '0);
        flags_o.lt  = res_i[XLEN-1];
        flags_o.gt  = !res_i[XLEN-1] && !is_zero;
        flags_o.eq  = is_zero;
        flags_o.so  = so_i;
    end
endmodule

// File: rtl/shadd_unit.sv
module shadd_unit #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] ra_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [SH_W-1:0] sh_i,
    input  logic [1:0]      mode_i,
    input  logic            rc_i,
    input  logic            so_i,
    output logic [XLEN-1:0] sum_o,
    output logic [3:0]      cr0_o
);
    import shadd_pkg::*;

    shadd_mode_e  mode_sel;
    logic [XLEN-1:0] ext_val;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] sum_next;
    cond_field_t  flags_next;
    cond_field_t  cr0_q;

    assign mode_sel = shadd_mode_e'(mode_i);

    shadd_extend #(.XLEN(XLEN)) u_extend (
        .rb_i   (rb_i),
        .mode_i (mode_sel),
        .ext_o  (ext_val)
    );

    shadd_shift #(.XLEN(XLEN), .SH_W(SH_W)) u_shift (
        .val_i     (ext_val),
        .sh_i      (sh_i),
        .shifted_o (shifted)
    );

    assign sum_next = shifted + ra_i;

    shadd_flags #(.XLEN(XLEN)) u_flags (
        .res_i   (sum_next),
        .so_i    (so_i),
        .flags_o (flags_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o <= '0;
            cr0_q <= '0;
        end else begin
            sum_o <= sum_next;
            if (rc_i) begin
                cr0_q <= flags_next;
            end
        end
    end

    assign cr0_o = cr0_q;
endmodule

// File: rtl/shadd_unit_chk.sv
module shadd_unit_chk #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] ra_i,
    input logic            rc_i,
    input logic            so_i,
    input logic [XLEN-1:0] sum_o,
    input logic [3:0]      cr0_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1/R2: shift by at least one leaves bit 0 equal to A's bit 0
    p_low_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (sum_o[0] == $past(ra_i[0])));

    // R6: no record, field holds
    p_cr0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(rc_i)) |-> (cr0_o == $past(cr0_o)));

    // R7: exactly one relation flag after a record
    p_cr0_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rc_i)) |-> ($countones(cr0_o[3:1]) == 1));

    // R7: EQ agrees with the recorded sum
    p_eq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rc_i)) |-> (cr0_o[1] == (sum_o == '0)));

    // R7: LT agrees with the recorded sum's sign
    p_lt_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rc_i)) |-> (cr0_o[3] == sum_o[XLEN-1]));

    // R8: SO copied on record
    p_so_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rc_i)) |-> (cr0_o[0] == $past(so_i)));
endmodule

bind shadd_unit shadd_unit_chk #(.XLEN(XLEN), .SH_W(SH_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_i  (ra_i),
    .rc_i  (rc_i),
    .so_i  (so_i),
    .sum_o (sum_o),
    .cr0_o (cr0_o)
);

// File: tb/shadd_unit_tb.sv
module shadd_unit_tb;
    localparam int NV = 12;

    typedef struct packed {
        logic [63:0] ra;
        logic [63:0] rb;
        logic [1:0]  sh;
        logic [1:0]  mode;
        logic        rc;
        logic        so;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_1000, 64'h0000_0000_0000_0003, 2'd0, 2'b00, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd3, 2'b00, 1'b1, 1'b1},
        '{64'h1234_5678_9abc_def0, 64'h8000_0000_0000_0001, 2'd0, 2'b00, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0005, 64'hffff_ffff_8000_0000, 2'd1, 2'b01, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0005, 64'hffff_ffff_8000_0000, 2'd1, 2'b10, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0000, 64'haaaa_bbbb_7fff_ffff, 2'd2, 2'b01, 1'b0, 1'b0},
        '{64'h0000_0000_0000_0000, 64'haaaa_bbbb_7fff_ffff, 2'd2, 2'b00, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0000, 64'haaaa_bbbb_7fff_ffff, 2'd2, 2'b11, 1'b1, 1'b1},
        '{64'h0000_0000_0000_0008, 64'hffff_ffff_ffff_fffc, 2'd0, 2'b00, 1'b1, 1'b0},
        '{64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0000, 2'd1, 2'b10, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0010, 64'h0000_0000_ffff_fffe, 2'd2, 2'b01, 1'b0, 1'b1},
        '{64'hf000_0000_0000_0000, 64'h1000_0000_0000_0000, 2'd3, 2'b00, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ra_i = '0, rb_i = '0;
    logic [1:0]  sh_i = '0, mode_i = '0;
    logic        rc_i = 1'b0, so_i = 1'b0;
    logic [63:0] sum_o;
    logic [3:0]  cr0_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] model_cr0 = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shadd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ra_i(ra_i), .rb_i(rb_i), .sh_i(sh_i),
        .mode_i(mode_i), .rc_i(rc_i), .so_i(so_i), .sum_o(sum_o), .cr0_o(cr0_o)
    );

    function automatic logic [63:0] ref_sum(vec_t v);
        logic [63:0] opnd;
        case (v.mode)
            2'b01:   opnd = {{32{v.rb[31]}}, v.rb[31:0]};
            2'b10:   opnd = {32'h0, v.rb[31:0]};
            default: opnd = v.rb;
        endcase
        return (opnd << (int'(v.sh) + 1)) + v.ra;
    endfunction

    function automatic logic [3:0] ref_flags(logic [63:0] s, logic so);
        return {s[63], (!s[63] && s != 0), (s == 0), so};
    endfunction

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(vec_t v, string req);
        logic [63:0] es;
        @(negedge clk);
        ra_i = v.ra; rb_i = v.rb; sh_i = v.sh; mode_i = v.mode;
        rc_i = v.rc; so_i = v.so;
        es = ref_sum(v);
        if (v.rc) model_cr0 = ref_flags(es, v.so);
        @(negedge clk);
        check64({req, " sum"}, sum_o, es);
        check64("R6 R7 R8 cr0", {60'h0, cr0_o}, {60'h0, model_cr0});
    endtask

    initial begin
        #20000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R9: reset state
        check64("R9 reset sum", sum_o, 64'h0);
        check64("R9 reset cr0", {60'h0, cr0_o}, 64'h0);
        rst_n = 1'b1;

        // R1..R8 table
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], "R1 R2 R3 R4 R5");
        end

        // R1: each shift code on B=1, A=0
        for (int s = 0; s < 4; s++) begin
            v = '{64'h0, 64'h1, 2'(s), 2'b00, 1'b1, 1'b0};
            run_vec(v, "R1 distance");
            check64("R1 exact", sum_o, 64'h1 << (s + 1));
        end

        // R2: wrap modulo 2^64, carry dropped
        v = '{64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 2'd0, 2'b00, 1'b1, 1'b0};
        run_vec(v, "R2 wrap");
        check64("R2 zero eq", {60'h0, cr0_o}, 64'h2);

        // R6: rc low, new sum while field holds (both in the same edge)
        v = '{64'h0, 64'hffff_ffff_ffff_ffff, 2'd0, 2'b00, 1'b0, 1'b1};
        run_vec(v, "R6 sum updates");
        check64("R6 held", {60'h0, cr0_o}, 64'h2);

        // R9: one-cycle latency; before the edge output still shows old value
        @(negedge clk);
        ra_i = 64'h77; rb_i = 64'h0; rc_i = 1'b0;
        #1;
        check64("R9 latency before edge", sum_o, 64'hffff_ffff_ffff_fffe);
        @(negedge clk);
        check64("R9 latency after edge", sum_o, 64'h77);

        // R9: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check64("R9 async reset sum", sum_o, 64'h0);
        check64("R9 async reset cr0", {60'h0, cr0_o}, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule